// File: doc/BRIEF.md
# Eight-Channel Start/Stop Interval Digitizer

This block measures time intervals as clocked counts. One shared start pulse opens a conversion. Each of the eight channels then waits for the rising edge of its own stop input, and a shared test stop acts on every channel at once. A timebase counter runs during the conversion. On each channel's first stop, the counter value is latched into that channel's 10-bit result. The timebase is restarted in phase with the start edge, so no free-running clock phase is added to the reading. A two-bit range input sets a prescaler of 1, 2 or 5 ahead of the counter, which widens the full scale at the cost of coarser bins.

A conversion ends in one of three ways: every channel has taken a stop, the counter reaches its last bin, or a clear is applied. Channels still waiting at full scale report all-ones with an overflow flag. The fast clear aborts the conversion from any state and then holds off new starts for a settling lockout. The lockout is derived from a 2 µs recovery time and the clock rate. The global clear returns the block to idle with no lockout. Start edges are recognised only while idle, and stops are recognised only during a conversion.

Top module: `interval_digitizer`

## Requirements
- R1: After reset, every result is 0, the hit, overflow and done outputs are all 0, and the block is idle.
- R2: Range code 0 sets a divisor D of 1, code 1 sets D = 2, and codes 2 and 3 set D = 5. Suppose the rising edge of a channel's stop is sampled N clock edges after the edge that samples the start rising edge. The channel then stores floor((N-1)/D) and sets its hit bit.
- R3: The range code is taken at the start edge. Changing range_i during a conversion does not change the divisor of that conversion.
- R4: A stop edge seen while no conversion is running sets no hit bit and stores no result.
- R5: A channel accepts only the first stop of a conversion. Later stops on that channel leave its result unchanged.
- R6: A test stop edge acts as a stop on every channel that has no hit yet, in the same cycle, so all of them store the same value.
- R7: If the counter reaches 2^CNT_W-1 and a tick ends that bin, the conversion ends. Each channel without a hit stores all-ones and sets its overflow bit.
- R8: done_o rises only after every channel holds either hit or overflow, within two cycles of the last hit. A new start, a fast clear or a global clear drops it.
- R9: A fast clear sampled high clears all results, hit, overflow and done on the next edge and ends any conversion. Stops that follow it have no effect.
- R10: After a fast clear, start edges are ignored for LOCK_CYCLES clock edges, where LOCK_CYCLES = CLK_MHZ*SETTLE_NS/1000. A start after that window is accepted.
- R11: A start edge during a conversion is ignored, and the count continues from the original start.
- R12: A global clear empties the block like a fast clear but imposes no lockout. A start on the very next edge is accepted.
- R13: A channel's hit and overflow bits are never both set, and overflow is only set while its result is all-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; it also serves as the measurement timebase |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Common start; its rising edge opens a conversion |
| stop_i | input | NUM_CH | Per-channel stop inputs, edge sensitive |
| test_stop_i | input | 1 | Shared stop that acts on all channels at once |
| fast_clr_i | input | 1 | Aborts the conversion and starts the settling lockout |
| clr_i | input | 1 | Global synchronous clear to idle, no lockout |
| range_i | input | 2 | Range code: 0 gives /1, 1 gives /2, 2 and 3 give /5 |
| result_o | output | NUM_CH*CNT_W | Channel results, channel k in bits [k*CNT_W +: CNT_W] |
| hit_o | output | NUM_CH | Channel took a stop in this conversion |
| ovf_o | output | NUM_CH | Channel reached full scale without a stop |
| done_o | output | 1 | Conversion complete, results final |

## Verification
Some properties can be checked on every cycle whatever the stimulus. These are: hit and overflow are exclusive, overflow implies an all-ones result, a latched result is frozen, hits only arise during a conversion, done rises only when every channel is resolved, both clears empty the block, and no conversion begins inside the lockout window. The actual count values need the bench's timed scenarios, since those depend on the distance between start and stop and on the range code. The same holds for the ignored second start, the range sampled only at start, the full-scale overflow pattern, and the moment the lockout lets a start through.

// File: rtl/idg_pkg.sv
package idg_pkg;

   localparam int DIV_W = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CONV = 2'd1,
      ST_LOCK = 2'd2
   } idg_state_e;

   // Range code to prescale divisor: bins widen in the ratio 1:2:5
   function automatic logic [DIV_W-1:0] range_divisor(input logic [1:0] sel);
      case (sel)
         2'd0:    return DIV_W'(1);
         2'd1:    return DIV_W'(2);
         default: return DIV_W'(5);
      endcase
   endfunction

endpackage

// File: rtl/idg_timebase.sv
module idg_timebase
   import idg_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             tick_o
);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] presc_q;
   logic [CNT_W-1:0] cnt_q;

   assign tick_o = run_i && (presc_q == div_q - DIV_W'(1));
   assign cnt_o  = cnt_q;

   // Prescaler and counter both restart on the accepted start edge,
   // which keeps the bin boundaries in phase with the start.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= DIV_W'(1);
         presc_q <= '0;
         cnt_q   <= '0;
      end else if (restart_i) begin
         div_q   <= div_i;
         presc_q <= '0;
         cnt_q   <= '0;
      end else if (run_i) begin
         if (tick_o) begin
            presc_q <= '0;
            cnt_q   <= cnt_q + CNT_W'(1);
         end else begin
            presc_q <= presc_q + DIV_W'(1);
         end
      end
   end

endmodule

// File: rtl/idg_ctrl.sv
module idg_ctrl
   import idg_pkg::*;
#(
   parameter int CNT_W       = 10,
   parameter int LOCK_CYCLES = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             clr_i,
   input  logic             fast_clr_i,
   input  logic             all_hit_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             start_go_o,
   output logic             flush_o,
   output logic             conv_o,
   output logic             fs_end_o,
   output logic             done_o
);

   localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);

   idg_state_e        state_q;
   logic              start_q;
   logic              done_q;
   logic [LOCK_W-1:0] lock_q;
   logic              start_edge;
   logic              all_end;

   assign start_edge = start_i && !start_q;
   assign conv_o     = (state_q == ST_CONV);
   assign start_go_o = start_edge && (state_q == ST_IDLE) && !clr_i && !fast_clr_i;
   assign fs_end_o   = conv_o && tick_i && (cnt_i == {CNT_W{1'b1}});
   assign all_end    = conv_o && all_hit_i;
   assign flush_o    = clr_i || fast_clr_i || start_go_o;
   assign done_o     = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
      end else begin
         start_q <= start_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         lock_q  <= '0;
      end else if (clr_i) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         lock_q  <= '0;
      end else if (fast_clr_i) begin
         state_q <= ST_LOCK;
         done_q  <= 1'b0;
         lock_q  <= LOCK_W'(LOCK_CYCLES - 1);
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_go_o) begin
                  state_q <= ST_CONV;
                  done_q  <= 1'b0;
               end
            end
            ST_CONV: begin
               if (fs_end_o || all_end) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            ST_LOCK: begin
               if (lock_q == '0) begin
                  state_q <= ST_IDLE;
               end else begin
                  lock_q <= lock_q - LOCK_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/idg_channel.sv
module idg_channel #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_i,
   input  logic             test_edge_i,
   input  logic             flush_i,
   input  logic             arm_i,
   input  logic             fs_end_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] res_o,
   output logic             hit_o,
   output logic             ovf_o
);

   logic             stop_q;
   logic             stop_edge;
   logic [CNT_W-1:0] res_q;
   logic             hit_q;
   logic             ovf_q;

   assign stop_edge = (stop_i && !stop_q) || test_edge_i;
   assign res_o     = res_q;
   assign hit_o     = hit_q;
   assign ovf_o     = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
      end else begin
         stop_q <= stop_i;
      end
   end

   // A stop edge wins over full scale in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         hit_q <= 1'b0;
         ovf_q <= 1'b0;
      end else if (flush_i) begin
         res_q <= '0;
         hit_q <= 1'b0;
         ovf_q <= 1'b0;
      end else if (arm_i && !hit_q && !ovf_q) begin
         if (stop_edge) begin
            res_q <= cnt_i;
            hit_q <= 1'b1;
         end else if (fs_end_i) begin
            res_q <= {CNT_W{1'b1}};
            ovf_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/interval_digitizer.sv
module interval_digitizer
   import idg_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int CNT_W     = 10,
   parameter int CLK_MHZ   = 50,
   parameter int SETTLE_NS = 2000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [NUM_CH-1:0]       stop_i,
   input  logic                    test_stop_i,
   input  logic                    fast_clr_i,
   input  logic                    clr_i,
   input  logic [1:0]              range_i,
   output logic [NUM_CH*CNT_W-1:0] result_o,
   output logic [NUM_CH-1:0]       hit_o,
   output logic [NUM_CH-1:0]       ovf_o,
   output logic                    done_o
);

   localparam int LOCK_CYCLES = (CLK_MHZ * SETTLE_NS) / 1000;

   if (NUM_CH < 1) begin : g_err_ch
      $error("interval_digitizer: NUM_CH must be at least 1");
   end
   if (CNT_W < 2) begin : g_err_w
      $error("interval_digitizer: CNT_W must be at least 2");
   end
   if (LOCK_CYCLES < 1) begin : g_err_lock
      $error("interval_digitizer: settling lockout must be at least one cycle");
   end

   logic             test_q;
   logic             test_edge;
   logic             start_go;
   logic             flush;
   logic             conv_w;
   logic             fs_end;
   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic [DIV_W-1:0] div_sel;

   assign div_sel   = range_divisor(range_i);
   assign test_edge = test_stop_i && !test_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         test_q <= 1'b0;
      end else begin
         test_q <= test_stop_i;
      end
   end

   idg_ctrl #(
      .CNT_W      (CNT_W),
      .LOCK_CYCLES(LOCK_CYCLES)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .clr_i      (clr_i),
      .fast_clr_i (fast_clr_i),
      .all_hit_i  (&hit_o),
      .tick_i     (tick),
      .cnt_i      (cnt),
      .start_go_o (start_go),
      .flush_o    (flush),
      .conv_o     (conv_w),
      .fs_end_o   (fs_end),
      .done_o     (done_o)
   );

   idg_timebase #(
      .CNT_W(CNT_W)
   ) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart_i(start_go),
      .run_i    (conv_w),
      .div_i    (div_sel),
      .cnt_o    (cnt),
      .tick_o   (tick)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      idg_channel #(
         .CNT_W(CNT_W)
      ) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .stop_i     (stop_i[g]),
         .test_edge_i(test_edge),
         .flush_i    (flush),
         .arm_i      (conv_w),
         .fs_end_i   (fs_end),
         .cnt_i      (cnt),
         .res_o      (result_o[g*CNT_W +: CNT_W]),
         .hit_o      (hit_o[g]),
         .ovf_o      (ovf_o[g])
      );
   end

endmodule

// File: rtl/idg_checker.sv
module idg_checker #(
   parameter int NUM_CH      = 8,
   parameter int CNT_W       = 10,
   parameter int LOCK_CYCLES = 100
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    clr_i,
   input logic                    fast_clr_i,
   input logic                    busy_i,
   input logic                    done_o,
   input logic [NUM_CH-1:0]       hit_o,
   input logic [NUM_CH-1:0]       ovf_o,
   input logic [NUM_CH*CNT_W-1:0] result_o
);

   localparam int SINCE_W = $clog2(LOCK_CYCLES + 2) + 1;
   localparam logic [SINCE_W-1:0] SINCE_MAX = SINCE_W'(LOCK_CYCLES + 1);

   // Cycles since the last fast clear, saturating; a global clear ends the window
   logic [SINCE_W-1:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= SINCE_MAX;
      end else if (clr_i) begin
         since_q <= SINCE_MAX;
      end else if (fast_clr_i) begin
         since_q <= '0;
      end else if (since_q != SINCE_MAX) begin
         since_q <= since_q + SINCE_W'(1);
      end
   end

   assert_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o & ovf_o) == '0);

   assert_done_resolved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> &(hit_o | ovf_o));

   assert_fast_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fast_clr_i |=> (hit_o == '0 && ovf_o == '0 && !done_o && !busy_i && result_o == '0));

   assert_global_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (hit_o == '0 && ovf_o == '0 && !done_o && !busy_i && result_o == '0));

   assert_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_i) |-> (since_q >= SINCE_W'(LOCK_CYCLES)));

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      assert_ovf_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_o[g] |-> (result_o[g*CNT_W +: CNT_W] == {CNT_W{1'b1}}));

      assert_first_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
         hit_o[g] |=> (!hit_o[g] || $stable(result_o[g*CNT_W +: CNT_W])));

      assert_armed_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(hit_o[g]) |-> $past(busy_i));
   end

endmodule

bind interval_digitizer idg_checker #(
   .NUM_CH     (NUM_CH),
   .CNT_W      (CNT_W),
   .LOCK_CYCLES(LOCK_CYCLES)
) u_idg_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_i     (clr_i),
   .fast_clr_i(fast_clr_i),
   .busy_i    (conv_w),
   .done_o    (done_o),
   .hit_o     (hit_o),
   .ovf_o     (ovf_o),
   .result_o  (result_o)
);

// File: tb/tb_interval_digitizer.sv
module tb_interval_digitizer;

   localparam int NCH = 8;
   localparam int CW  = 10;
   localparam int NV  = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start_i;
   logic [NCH-1:0]    stop_i;
   logic              test_stop_i;
   logic              fast_clr_i;
   logic              clr_i;
   logic [1:0]        range_i;
   logic [NCH*CW-1:0] result_o;
   logic [NCH-1:0]    hit_o;
   logic [NCH-1:0]    ovf_o;
   logic              done_o;

   int checks = 0;
   int fails  = 0;
   int tnow   = 0;

   always #10 clk = ~clk;

   interval_digitizer #(
      .NUM_CH   (NCH),
      .CNT_W    (CW),
      .CLK_MHZ  (50),
      .SETTLE_NS(2000)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .stop_i     (stop_i),
      .test_stop_i(test_stop_i),
      .fast_clr_i (fast_clr_i),
      .clr_i      (clr_i),
      .range_i    (range_i),
      .result_o   (result_o),
      .hit_o      (hit_o),
      .ovf_o      (ovf_o),
      .done_o     (done_o)
   );

   // {range[1:0], channel[2:0], N[12:0], expected[9:0]}; expected = floor((N-1)/D)
   localparam logic [27:0] VEC [NV] = '{
      {2'd0, 3'd0, 13'd1,    10'd0},
      {2'd0, 3'd1, 13'd100,  10'd99},
      {2'd1, 3'd2, 13'd7,    10'd3},
      {2'd1, 3'd3, 13'd2000, 10'd999},
      {2'd2, 3'd4, 13'd12,   10'd2},
      {2'd2, 3'd5, 13'd5,    10'd0},
      {2'd3, 3'd6, 13'd26,   10'd5},
      {2'd0, 3'd7, 13'd1023, 10'd1022}
   };

   function automatic logic [CW-1:0] res_of(input int ch);
      return result_o[ch*CW +: CW];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic begin_conv(input logic [1:0] rng);
      @(negedge clk);
      range_i = rng;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      tnow = 0;
   endtask

   task automatic stop_at(input int ch, input int n);
      repeat (n - 1 - tnow) @(negedge clk);
      stop_i[ch] = 1'b1;
      @(negedge clk);
      stop_i[ch] = 1'b0;
      tnow = n;
   endtask

   task automatic test_at(input int n);
      repeat (n - 1 - tnow) @(negedge clk);
      test_stop_i = 1'b1;
      @(negedge clk);
      test_stop_i = 1'b0;
      tnow = n;
   endtask

   task automatic start_at(input int n);
      repeat (n - 1 - tnow) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      tnow = n;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      tnow = tnow + n;
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; stop_i = '0; test_stop_i = 1'b0;
      fast_clr_i = 1'b0; clr_i = 1'b0; range_i = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 result", result_o, '0);
      chk("R1 hit", hit_o, '0);
      chk("R1 ovf", ovf_o, '0);
      chk("R1 done", done_o, 0);

      // Vector table: R2 count value, R3 range codes
      for (int v = 0; v < NV; v++) begin
         begin_conv(VEC[v][27:26]);
         stop_at(int'(VEC[v][25:23]), int'(VEC[v][22:10]));
         test_at(int'(VEC[v][22:10]) + 1);
         idle(3);
         chk("R2 R3 result", res_of(int'(VEC[v][25:23])), VEC[v][9:0]);
         chk("R2 hit", hit_o[VEC[v][25:23]], 1);
      end

      // R4 stop before any start is ignored
      clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
      stop_i[0] = 1'b1; @(negedge clk); stop_i[0] = 1'b0;
      idle(2);
      chk("R4 idle stop hit", hit_o, '0);
      begin_conv(2'd0);
      test_at(10);
      idle(3);
      chk("R4 result after start", res_of(0), 9);

      // R5 second stop discarded; R6 test stop gives equal values
      begin_conv(2'd0);
      stop_at(2, 5);
      stop_at(2, 20);
      test_at(30);
      idle(3);
      chk("R5 first stop kept", res_of(2), 4);
      chk("R6 all hit", hit_o, 8'hFF);
      chk("R6 ch0 value", res_of(0), 29);
      chk("R6 ch7 value", res_of(7), 29);

      // R8 done only once all channels resolved
      begin_conv(2'd0);
      for (int c = 0; c < NCH - 1; c++) stop_at(c, 3 + c);
      idle(3);
      chk("R8 done held low", done_o, 0);
      stop_at(7, 15);
      idle(3);
      chk("R8 done high", done_o, 1);
      chk("R8 last value", res_of(7), 14);

      // R11 start during conversion ignored
      begin_conv(2'd0);
      start_at(10);
      stop_at(1, 40);
      test_at(41);
      idle(3);
      chk("R11 count not restarted", res_of(1), 39);

      // R3 range changed mid-conversion has no effect
      begin_conv(2'd0);
      range_i = 2'd2;
      stop_at(2, 50);
      test_at(51);
      idle(3);
      chk("R3 range held", res_of(2), 49);

      // R7 full scale overflow
      begin_conv(2'd0);
      stop_at(3, 10);
      idle(1100);
      chk("R7 done", done_o, 1);
      chk("R7 hit pattern", hit_o, 8'h08);
      chk("R7 ovf pattern", ovf_o, 8'hF7);
      chk("R7 hit value", res_of(3), 9);
      chk("R7 ovf value", res_of(0), 1023);

      // R9 fast clear aborts mid-conversion
      begin_conv(2'd0);
      stop_at(0, 5);
      fast_clr_i = 1'b1; @(negedge clk); fast_clr_i = 1'b0;
      chk("R9 hit cleared", hit_o, '0);
      chk("R9 result cleared", result_o, '0);
      chk("R9 done cleared", done_o, 0);
      stop_i[1] = 1'b1; @(negedge clk); stop_i[1] = 1'b0;
      @(negedge clk);
      chk("R9 later stop ignored", hit_o, '0);

      // R10 start inside lockout ignored, after lockout accepted
      idle(40);
      begin_conv(2'd0);
      stop_at(0, 3);
      idle(2);
      chk("R10 start in lockout", hit_o, '0);
      idle(100);
      begin_conv(2'd0);
      stop_at(0, 3);
      idle(1);
      chk("R10 start after lockout", hit_o[0], 1);
      chk("R10 value", res_of(0), 2);
      test_at(6);
      idle(3);

      // R12 global clear, no lockout
      begin_conv(2'd0);
      stop_at(4, 5);
      clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
      chk("R12 hit cleared", hit_o, '0);
      chk("R12 result cleared", result_o, '0);
      begin_conv(2'd0);
      stop_at(5, 4);
      idle(1);
      chk("R12 immediate start hit", hit_o[5], 1);
      chk("R12 immediate start value", res_of(5), 3);
      chk("R13 exclusive", hit_o & ovf_o, '0);
      test_at(8);
      idle(3);

      summary();
   end

endmodule